// File: doc/BRIEF.md
# Masked Polarity Interrupt Aggregator

This block collects a set of raw hardware interrupt lines and conditions each one before it reaches a downstream interrupt distributor. Every line first passes through its own polarity inversion, so a low-active source can be made to count as asserted. A per-line mask then decides whether the line may reach its output. Each line has one registered output.

A build-time switch selects one of two variants. The level variant (`FAST_MODE = 0`, 64 lines by default) passes the conditioned level straight to the output register. Software can read that level, before masking, through a raw-status bank. The latching variant (`FAST_MODE = 1`, used with 32 lines) holds each line in a small two-state machine. A line goes from `LN_IDLE` to `LN_PEND` on a rising edge of its conditioned level (transition "capture"). It stays in `LN_PEND` when the source falls (transition "hold"). It returns to `LN_IDLE` only when software writes a 1 to its clear bit and no new edge arrives in that cycle (transition "acknowledge"). An edge that coincides with the acknowledge keeps the line in `LN_PEND` (transition "re-arm").

Software uses a 16-bit register port with a word address, a write strobe, write data and read data. Reads are combinational. Each bank is split into 16-bit words, and word g of a bank covers lines 16g to 16g+15.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit reads 1, every polarity bit reads 0, every pending bit reads 0, and all outputs are 0.
- R2: The mask bank sits at word addresses 0 upward, one word per 16 lines (bit b of word g is line 16g+b). A mask bit of 0 lets the line through and a mask bit of 1 forces its output to 0.
- R3: The polarity bank sits at word addresses 8 upward with the same bit layout. The conditioned level of a line is its raw input XOR its polarity bit.
- R4: In the level variant, each output equals the conditioned level AND NOT the mask bit, as sampled at the previous clock edge (one register stage).
- R5: In the level variant, status word 16+g reads the conditioned levels of lines 16g..16g+15 whatever the mask, and writes to the status words change nothing.
- R6: In the latching variant, a rising edge of a line's conditioned level sets its pending bit, which stays set after the source falls. Pending bits read from status word 16+g.
- R7: In the latching variant, writing 1 to a status bit clears that pending bit at the write edge, and writing 0 leaves it unchanged.
- R8: In the latching variant, if a new rising edge arrives in the same cycle as a clear of that line, the line stays pending.
- R9: Reads from word addresses outside the implemented banks return 0, and writes to them change no register.
- R10: In the latching variant, each output equals the pending bit AND NOT the mask bit from the previous clock edge, so an output follows a captured edge two edges after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | NUM_LINES | Raw interrupt lines, already synchronous to clk |
| reg_addr | input | 5 | Register word address |
| reg_wr_en | input | 1 | Write strobe for the addressed word |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data of the addressed word, 0 when unmapped |
| irq_out | output | NUM_LINES | Conditioned, masked interrupt outputs toward the distributor |

## Verification
The hardest case to reach is the re-arm transition in the latching variant. A line must already be pending, its source must have gone low for at least one edge so the edge detector is primed, and then the rising source and the clear write must land on the same clock edge. The bench first captures and releases the line. It then changes the raw input and raises the write strobe for the clear in the same half-cycle, so both are seen at one edge, and reads the status word afterwards. It also uses a polarity write alone to make an edge, which shows that polarity changes reach the edge detector.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int GRP_W     = 16;
    localparam int ADDR_W    = 5;
    localparam int MASK_BASE = 0;
    localparam int POL_BASE  = 8;
    localparam int STAT_BASE = 16;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_agg_pkg::*;
#(
    parameter int NL   = 64,
    parameter bit FAST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [GRP_W-1:0]  wr_data,
    input  logic [NL-1:0]     stat_vec,
    output logic [GRP_W-1:0]  rd_data,
    output logic [NL-1:0]     mask_q,
    output logic [NL-1:0]     pol_q,
    output logic [NL-1:0]     clr_vec
);
    localparam int NG = NL / GRP_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NG; g++) begin
                if (addr == ADDR_W'(MASK_BASE + g))
                    mask_q[g*GRP_W +: GRP_W] <= wr_data;
                if (addr == ADDR_W'(POL_BASE + g))
                    pol_q[g*GRP_W +: GRP_W] <= wr_data;
            end
        end
    end

    always_comb begin
        clr_vec = '0;
        for (int g = 0; g < NG; g++) begin
            if (FAST && wr_en && (addr == ADDR_W'(STAT_BASE + g)))
                clr_vec[g*GRP_W +: GRP_W] = wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NG; g++) begin
            if (addr == ADDR_W'(MASK_BASE + g))
                rd_data = mask_q[g*GRP_W +: GRP_W];
            else if (addr == ADDR_W'(POL_BASE + g))
                rd_data = pol_q[g*GRP_W +: GRP_W];
            else if (addr == ADDR_W'(STAT_BASE + g))
                rd_data = stat_vec[g*GRP_W +: GRP_W];
        end
    end
endmodule

// File: rtl/irq_line_core.sv
module irq_line_core
    import irq_agg_pkg::*;
#(
    parameter int NL   = 64,
    parameter bit FAST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] raw,
    input  logic [NL-1:0] pol,
    input  logic [NL-1:0] clr_vec,
    output logic [NL-1:0] level_vec,
    output logic [NL-1:0] edge_vec,
    output logic [NL-1:0] pend_vec
);
    assign level_vec = raw ^ pol;

    generate
        if (FAST) begin : g_latch
            logic [NL-1:0] prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= level_vec;
            end

            assign edge_vec = level_vec & ~prev_q;

            for (genvar i = 0; i < NL; i++) begin : g_line
                line_state_e st_q, st_d;

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) st_q <= LN_IDLE;
                    else        st_q <= st_d;
                end

                always_comb begin
                    st_d = st_q;
                    unique case (st_q)
                        LN_IDLE: if (edge_vec[i]) st_d = LN_PEND;
                        LN_PEND: if (clr_vec[i] && !edge_vec[i]) st_d = LN_IDLE;
                        default: st_d = LN_IDLE;
                    endcase
                end

                assign pend_vec[i] = (st_q == LN_PEND);
            end
        end else begin : g_level
            assign edge_vec = '0;
            assign pend_vec = level_vec;
        end
    endgenerate
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int NL = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] src_vec,
    input  logic [NL-1:0] mask_vec,
    output logic [NL-1:0] irq_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= src_vec & ~mask_vec;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter bit FAST_MODE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [GRP_W-1:0]     reg_wr_data,
    output logic [GRP_W-1:0]     reg_rd_data,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] level_vec;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] pend_vec;

    irq_regbank #(.NL(NUM_LINES), .FAST(FAST_MODE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .stat_vec (pend_vec),
        .rd_data  (reg_rd_data),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .clr_vec  (clr_vec)
    );

    irq_line_core #(.NL(NUM_LINES), .FAST(FAST_MODE)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (irq_raw),
        .pol       (pol_q),
        .clr_vec   (clr_vec),
        .level_vec (level_vec),
        .edge_vec  (edge_vec),
        .pend_vec  (pend_vec)
    );

    irq_out_stage #(.NL(NUM_LINES)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_vec  (pend_vec),
        .mask_vec (mask_q),
        .irq_out  (irq_out)
    );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int NL   = 64,
    parameter bit FAST = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] irq_out,
    input logic [NL-1:0] mask_vec,
    input logic [NL-1:0] level_vec,
    input logic [NL-1:0] edge_vec,
    input logic [NL-1:0] pend_vec,
    input logic [NL-1:0] clr_vec
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

    p_masked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & $past(mask_vec)) == '0);

    generate
        if (FAST) begin : g_fast
            p_out_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out == $past(pend_vec & ~mask_vec));

            p_set_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_vec & ~$past(pend_vec) & ~$past(edge_vec)) == '0);

            p_hold_until_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pend_vec) & ~$past(clr_vec) & ~pend_vec) == '0);

            p_race_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (($past(edge_vec & clr_vec) & ~pend_vec) == '0));
        end else begin : g_level
            p_level_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out == $past(level_vec & ~mask_vec));
        end
    endgenerate
endmodule

bind irq_aggregator irq_agg_checker #(.NL(NUM_LINES), .FAST(FAST_MODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .mask_vec  (mask_q),
    .level_vec (level_vec),
    .edge_vec  (edge_vec),
    .pend_vec  (pend_vec),
    .clr_vec   (clr_vec)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [63:0] n_raw = '0;
    logic [4:0]  n_addr = '0;
    logic        n_we = 1'b0;
    logic [15:0] n_wd = '0;
    logic [15:0] n_rd;
    logic [63:0] n_out;

    logic [31:0] f_raw = '0;
    logic [4:0]  f_addr = '0;
    logic        f_we = 1'b0;
    logic [15:0] f_wd = '0;
    logic [15:0] f_rd;
    logic [31:0] f_out;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NUM_LINES(64), .FAST_MODE(1'b0)) i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_raw(n_raw), .reg_addr(n_addr),
        .reg_wr_en(n_we), .reg_wr_data(n_wd), .reg_rd_data(n_rd), .irq_out(n_out)
    );

    irq_aggregator #(.NUM_LINES(32), .FAST_MODE(1'b1)) i_irq_aggregator_fast (
        .clk(clk), .rst_n(rst_n), .irq_raw(f_raw), .reg_addr(f_addr),
        .reg_wr_en(f_we), .reg_wr_data(f_wd), .reg_rd_data(f_rd), .irq_out(f_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input bit fast, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        if (fast) begin f_addr = a; f_wd = d; f_we = 1'b1; end
        else      begin n_addr = a; n_wd = d; n_we = 1'b1; end
        @(negedge clk);
        f_we = 1'b0;
        n_we = 1'b0;
    endtask

    task automatic rd(input bit fast, input logic [4:0] a, output logic [15:0] d);
        if (fast) f_addr = a; else n_addr = a;
        #1;
        d = fast ? f_rd : n_rd;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 level outputs", n_out, 64'h0);
        chk("R1 latch outputs", {32'h0, f_out}, 64'h0);
        rd(0, 5'd0, d);  chk("R1 mask word0", {48'h0, d}, 64'hFFFF);
        rd(0, 5'd3, d);  chk("R1 mask word3", {48'h0, d}, 64'hFFFF);
        rd(0, 5'd9, d);  chk("R1 polarity word1", {48'h0, d}, 64'h0);
        rd(1, 5'd16, d); chk("R1 pending word0", {48'h0, d}, 64'h0);
    endtask

    task automatic t_mask_level();
        n_raw[5] = 1'b1; n_raw[40] = 1'b1;
        step();
        chk("R2 blocked by reset mask", n_out, 64'h0);
        wr(0, 5'd0, ~16'h0020);
        step();
        chk("R2 R4 line 5 unmasked", n_out, 64'h20);
        wr(0, 5'd2, ~16'h0100);
        step();
        chk("R2 word2 maps line 40", n_out, 64'h0000_0100_0000_0020);
        n_raw[5] = 1'b0;
        step();
        chk("R4 level follows input", n_out, 64'h0000_0100_0000_0000);
        n_raw[40] = 1'b0;
        step();
    endtask

    task automatic t_polarity_level();
        wr(0, 5'd1, ~16'h0002);
        step();
        chk("R3 line 17 low, no inversion", n_out[17], 1'b0);
        wr(0, 5'd9, 16'h0002);
        step();
        chk("R3 inverted low input asserts", n_out[17], 1'b1);
        n_raw[17] = 1'b1;
        step();
        chk("R3 inverted high input quiet", n_out[17], 1'b0);
        n_raw[17] = 1'b0;
        step();
    endtask

    task automatic t_raw_status();
        logic [15:0] d;
        n_raw[50] = 1'b1;
        rd(0, 5'd19, d);
        chk("R5 raw status sees masked line", {48'h0, d}, 64'h0004);
        step();
        chk("R5 masked line output stays low", n_out[50], 1'b0);
        wr(0, 5'd19, 16'hFFFF);
        rd(0, 5'd19, d);
        chk("R5 status write has no effect", {48'h0, d}, 64'h0004);
        rd(0, 5'd3, d);
        chk("R5 status write leaves mask", {48'h0, d}, 64'hFFFF);
        n_raw[50] = 1'b0;
        rd(0, 5'd19, d);
        chk("R5 status is level driven", {48'h0, d}, 64'h0);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        wr(0, 5'd4, 16'h0000);
        rd(0, 5'd4, d);  chk("R9 unmapped word4 reads 0", {48'h0, d}, 64'h0);
        rd(0, 5'd31, d); chk("R9 unmapped word31 reads 0", {48'h0, d}, 64'h0);
        rd(0, 5'd0, d);  chk("R9 mask word0 unchanged", {48'h0, d}, 64'hFFDF);
        rd(0, 5'd2, d);  chk("R9 mask word2 unchanged", {48'h0, d}, 64'hFEFF);
        wr(1, 5'd2, 16'h1234);
        rd(1, 5'd2, d);  chk("R9 latch word2 beyond 32 lines", {48'h0, d}, 64'h0);
        rd(1, 5'd18, d); chk("R9 latch status word2 reads 0", {48'h0, d}, 64'h0);
    endtask

    task automatic t_latch();
        logic [15:0] d;
        f_raw[3] = 1'b1;
        step();
        rd(1, 5'd16, d);
        chk("R6 edge captured", {48'h0, d}, 64'h0008);
        step();
        chk("R2 captured line masked", {32'h0, f_out}, 64'h0);
        f_raw[3] = 1'b0;
        step(); step();
        rd(1, 5'd16, d);
        chk("R6 pending held after source falls", {48'h0, d}, 64'h0008);
        wr(1, 5'd0, 16'h0000);
        chk("R10 output still low one edge after unmask", {32'h0, f_out}, 64'h0);
        step();
        chk("R10 output after unmask", {32'h0, f_out}, 64'h0008);
    endtask

    task automatic t_clear();
        logic [15:0] d;
        wr(1, 5'd16, 16'h0000);
        rd(1, 5'd16, d);
        chk("R7 zero write keeps pending", {48'h0, d}, 64'h0008);
        wr(1, 5'd16, 16'h0008);
        rd(1, 5'd16, d);
        chk("R7 one write clears pending", {48'h0, d}, 64'h0);
        chk("R10 output lags clear by one edge", {32'h0, f_out}, 64'h0008);
        step();
        chk("R10 output low after clear", {32'h0, f_out}, 64'h0);
        f_raw[11] = 1'b1;
        step(); step();
        chk("R10 edge to output two edges", {32'h0, f_out}, 64'h0800);
        f_raw[11] = 1'b0;
        wr(1, 5'd16, 16'h0800);
        step();
    endtask

    task automatic t_race();
        logic [15:0] d;
        f_raw[20] = 1'b1;
        step();
        f_raw[20] = 1'b0;
        step();
        rd(1, 5'd17, d);
        chk("R6 line 20 pending in word1", {48'h0, d}, 64'h0010);
        @(negedge clk);
        f_raw[20] = 1'b1;
        f_addr = 5'd17; f_wd = 16'h0010; f_we = 1'b1;
        @(negedge clk);
        f_we = 1'b0;
        rd(1, 5'd17, d);
        chk("R8 edge during clear stays pending", {48'h0, d}, 64'h0010);
        wr(1, 5'd17, 16'h0010);
        rd(1, 5'd17, d);
        chk("R7 clear with steady high source", {48'h0, d}, 64'h0);
        f_raw[20] = 1'b0;
        step();
    endtask

    task automatic t_polarity_latch();
        logic [15:0] d;
        wr(1, 5'd8, 16'h0080);
        step();
        rd(1, 5'd16, d);
        chk("R3 polarity write makes edge", {48'h0, d}, 64'h0080);
        step();
        chk("R3 R10 inverted line reaches output", {32'h0, f_out}, 64'h0080);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mask_level();
        t_polarity_level();
        t_raw_status();
        t_unmapped();
        t_latch();
        t_clear();
        t_race();
        t_polarity_latch();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule